// File: doc/BRIEF.md
# Seconds Real-Time Clock with Dual Alarm Match

This block is a register-mapped seconds timekeeper for a small 32-bit peripheral bus. It keeps two 32-bit counters driven by an external one-second tick: an elapsed-seconds counter that counts up and a mirror counter that counts down. Firmware loads the mirror with the complement of the seconds value, so the two always sum to all ones. A freeze bit in the control register stops both counters, so firmware can load them as a pair without a tick arriving between the two writes.

Two compare registers watch the seconds counter. Each one latches a status flag when the values are equal and its enable is on. The flags feed an interrupt line and a power-switch output. The power-switch output can also be forced high, and its rising edge latches a third status flag. A software-reset bit clears the time state but keeps the compare values, a 32-bit initialisation marker register and a small scratch memory. Firmware checks the marker to see whether the clock was already set up before the last reset.

Top module: `secrtc_core`

## Requirements
- R1: After the reset input is released, every mapped location reads zero, and `irq` and `onsw` are low.
- R2: While the freeze bit (control bit 6) is clear, each `tick` pulse adds 1 to the up-counter (offset 0x00) and subtracts 1 from the down-counter (offset 0x04), modulo 2^32. After a complementary load, the two counters always sum to 0xFFFFFFFF.
- R3: While control bit 6 is set, `tick` has no effect and bus writes load the counters. While bit 6 is clear, bus writes to the counters are ignored.
- R4: Status bit k (k = 0 or 1, offset 0x14) is set one cycle after the up-counter equals compare register k (offsets 0x08 and 0x0C) while control bit k is set. This applies whether the equality came from a tick, a counter load or a compare write. The flag is never set while control bit k is clear.
- R5: A compare value of 0xFFFFFFFF matches when the up-counter reaches it, and the next tick wraps the up-counter to 0 and the down-counter to 0xFFFFFFFF.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If the match condition still holds with its enable on, the flag is set again one cycle after the clear.
- R7: `irq` is high exactly when some status bit k (k = 0 or 1) and its control bit k are both 1.
- R8: `onsw` is high when control bit 7 is set, or when status bit 0 is set together with control bit 2, or when status bit 1 is set together with control bit 3. Status bit 2 latches on each rising edge of `onsw` and is cleared by writing 1 to it.
- R9: While control bit 4 is set, both counters, all status bits and all other control bits go to zero, so control reads back 0x10. The compare registers, the marker register and the scratch memory keep their values.
- R10: Offset 0x18 is a 32-bit read/write marker register (firmware stores 0xB5C13F27 there). Only a bus write or the reset input changes it.
- R11: Scratch word n (n < `SCRATCH_WORDS`) is a 32-bit read/write location at offset 0x80 + 4n.
- R12: Offsets that are not word-aligned, or that map to no register, read zero, and writes to them change nothing. Control bit 5 and bits 31:8 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse per elapsed second |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |
| onsw | output | 1 | Power-switch request output |

## Verification
The bench builds the block with `SCRATCH_WORDS` = 8 and `ADDR_W` = 8. With these values the bench can visit all 64 aligned offsets of the window. These cover every register, every scratch word, and both unmapped ranges (0x1C to 0x7C and 0xA0 to 0xFC), for the reset check, the write-ignore check and the read-back check. The counters keep their full 32-bit width. The bench loads them with values close to the top of the range, so only a few ticks reach the all-ones match and the wrap, and forty consecutive ticks test the complement sum one by one.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;
  localparam int DW = 32;
  localparam int CTRL_W = 8;
  localparam int STAT_W = 3;
  localparam int N_CMP = 2;

  localparam logic [7:0] OFS_UP   = 8'h00;
  localparam logic [7:0] OFS_DN   = 8'h04;
  localparam logic [7:0] OFS_CMP0 = 8'h08;
  localparam logic [7:0] OFS_CMP1 = 8'h0C;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_MARK = 8'h18;
  localparam logic [7:0] OFS_RAM  = 8'h80;

  localparam int CB_EN0   = 0;
  localparam int CB_EN1   = 1;
  localparam int CB_SW0   = 2;
  localparam int CB_SW1   = 3;
  localparam int CB_SRST  = 4;
  localparam int CB_FRZ   = 6;
  localparam int CB_FORCE = 7;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDF;

  localparam int SB_SW = 2;

  typedef struct packed {
    logic up;
    logic dn;
    logic cmp0;
    logic cmp1;
    logic ctrl;
    logic stat;
    logic mark;
    logic ram;
  } sel_t;
endpackage

// File: rtl/secrtc_decode.sv
module secrtc_decode
  import secrtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORDS  = 32,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam int RAM_LO = int'(OFS_RAM);
  localparam int RAM_HI = RAM_LO + 4 * WORDS;

  logic [ADDR_W-1:0] ram_ofs;

  always_comb begin
    sel     = '0;
    ram_ofs = addr - ADDR_W'(OFS_RAM);
    idx     = IDX_W'(ram_ofs >> 2);
    if (addr[1:0] == 2'b00) begin
      if (addr == ADDR_W'(OFS_UP))        sel.up   = 1'b1;
      else if (addr == ADDR_W'(OFS_DN))   sel.dn   = 1'b1;
      else if (addr == ADDR_W'(OFS_CMP0)) sel.cmp0 = 1'b1;
      else if (addr == ADDR_W'(OFS_CMP1)) sel.cmp1 = 1'b1;
      else if (addr == ADDR_W'(OFS_CTRL)) sel.ctrl = 1'b1;
      else if (addr == ADDR_W'(OFS_STAT)) sel.stat = 1'b1;
      else if (addr == ADDR_W'(OFS_MARK)) sel.mark = 1'b1;
      else if (int'(addr) >= RAM_LO && int'(addr) < RAM_HI) sel.ram = 1'b1;
    end
  end
endmodule

// File: rtl/secrtc_counter.sv
module secrtc_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          frz,
  input  logic          srst,
  input  logic          ld_up,
  input  logic          ld_dn,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] up,
  output logic [DW-1:0] dn
);
  logic [DW-1:0] up_q, up_d, dn_q, dn_d;
  logic          cnt_en;

  assign cnt_en = srst | (frz & (ld_up | ld_dn)) | (~frz & tick);

  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (srst) begin
      up_d = '0;
      dn_d = '0;
    end else if (frz) begin
      if (ld_up) up_d = wdata;
      if (ld_dn) dn_d = wdata;
    end else if (tick) begin
      up_d = up_q + 1'b1;
      dn_d = dn_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else if (cnt_en) begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up = up_q;
  assign dn = dn_q;
endmodule

// File: rtl/secrtc_flag.sv
module secrtc_flag #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          srst,
  input  logic          clr,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] cmp,
  output logic          flag
);
  logic flag_q, flag_d, hit;

  assign hit = en & (cnt == cmp);

  always_comb begin
    flag_d = flag_q;
    if (srst)      flag_d = 1'b0;
    else if (clr)  flag_d = 1'b0;
    else if (hit)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/secrtc_scratch.sv
module secrtc_scratch #(
  parameter int DW    = 32,
  parameter int WORDS = 32,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic word_en;
    assign word_en = we & (idx == IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[w] <= '0;
      else if (word_en) mem_q[w] <= wdata;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/secrtc_core.sv
module secrtc_core
  import secrtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int SCRATCH_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              onsw
);
  localparam int IDX_W = $clog2(SCRATCH_WORDS);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  sel_t             sel;
  logic [IDX_W-1:0] ram_idx;
  logic             wr;

  secrtc_decode #(.ADDR_W(ADDR_W), .WORDS(SCRATCH_WORDS), .IDX_W(IDX_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .idx  (ram_idx)
  );

  assign wr = bus_en & bus_we;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en, frz, srst;

  assign frz  = ctrl_q[CB_FRZ];
  assign srst = ctrl_q[CB_SRST];

  always_comb begin
    ctrl_en = 1'b0;
    ctrl_d  = ctrl_q;
    if (wr & sel.ctrl) begin
      ctrl_en = 1'b1;
      ctrl_d  = bus_wdata[CTRL_W-1:0] & CTRL_MASK;
    end else if (srst) begin
      ctrl_en = 1'b1;
      ctrl_d  = ctrl_q & (CTRL_W'(1) << CB_SRST);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  logic [DW-1:0] up, dn;
  logic          ld_up, ld_dn, ld_any;

  assign ld_up  = wr & sel.up;
  assign ld_dn  = wr & sel.dn;
  assign ld_any = ld_up | ld_dn;

  secrtc_counter #(.DW(DW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .tick  (tick),
    .frz   (frz),
    .srst  (srst),
    .ld_up (ld_up),
    .ld_dn (ld_dn),
    .wdata (bus_wdata),
    .up    (up),
    .dn    (dn)
  );

  logic [DW-1:0]    cmp_q [N_CMP];
  logic [N_CMP-1:0] cmp_wr, en_vec, flag_vec, flag_clr;

  assign cmp_wr[0] = wr & sel.cmp0;
  assign cmp_wr[1] = wr & sel.cmp1;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)      cmp_q[k] <= '0;
      else if (cmp_wr[k]) cmp_q[k] <= bus_wdata;
    end

    assign en_vec[k]   = ctrl_q[CB_EN0 + k];
    assign flag_clr[k] = wr & sel.stat & bus_wdata[k];

    secrtc_flag #(.DW(DW)) u_flag (
      .clk   (clk),
      .rst_n (rst_s_n),
      .en    (en_vec[k]),
      .srst  (srst),
      .clr   (flag_clr[k]),
      .cnt   (up),
      .cmp   (cmp_q[k]),
      .flag  (flag_vec[k])
    );
  end

  logic onsw_q, sw_flag_q, sw_flag_d, sw_rise;

  assign onsw = ctrl_q[CB_FORCE]
              | (flag_vec[0] & ctrl_q[CB_SW0])
              | (flag_vec[1] & ctrl_q[CB_SW1]);
  assign sw_rise = onsw & ~onsw_q;

  always_comb begin
    sw_flag_d = sw_flag_q;
    if (srst)                                   sw_flag_d = 1'b0;
    else if (sw_rise)                           sw_flag_d = 1'b1;
    else if (wr & sel.stat & bus_wdata[SB_SW])  sw_flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      onsw_q    <= 1'b0;
      sw_flag_q <= 1'b0;
    end else begin
      onsw_q    <= onsw;
      sw_flag_q <= sw_flag_d;
    end
  end

  logic [STAT_W-1:0] stat_vec;
  assign stat_vec = {sw_flag_q, flag_vec};
  assign irq      = |(flag_vec & en_vec);

  logic [DW-1:0] mark_q;
  logic          mark_wr;
  assign mark_wr = wr & sel.mark;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    mark_q <= '0;
    else if (mark_wr) mark_q <= bus_wdata;
  end

  logic [DW-1:0] ram_rdata;

  secrtc_scratch #(.DW(DW), .WORDS(SCRATCH_WORDS), .IDX_W(IDX_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (wr & sel.ram),
    .idx   (ram_idx),
    .wdata (bus_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel.up)        bus_rdata = up;
    else if (sel.dn)   bus_rdata = dn;
    else if (sel.cmp0) bus_rdata = cmp_q[0];
    else if (sel.cmp1) bus_rdata = cmp_q[1];
    else if (sel.ctrl) bus_rdata = DW'(ctrl_q);
    else if (sel.stat) bus_rdata = DW'(stat_vec);
    else if (sel.mark) bus_rdata = mark_q;
    else if (sel.ram)  bus_rdata = ram_rdata;
  end
endmodule

// File: rtl/secrtc_chk.sv
module secrtc_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          frz,
  input logic          srst,
  input logic          ld_any,
  input logic [DW-1:0] up,
  input logic [DW-1:0] dn,
  input logic [DW-1:0] mark,
  input logic          mark_wr,
  input logic [2:0]    stat,
  input logic [1:0]    en,
  input logic          onsw
);
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !frz && !srst |=> (up == $past(up) + 1'b1) && (dn == $past(dn) - 1'b1)); // R2

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frz && !srst && !ld_any |=> $stable(up) && $stable(dn)); // R3

  AST_FLAG0_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(en[0])); // R4

  AST_FLAG1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(en[1])); // R4

  AST_ONSW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(onsw) && !srst |=> stat[2]); // R8

  AST_SRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (up == '0) && (dn == '0) && (stat == '0)); // R9

  AST_MARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_wr |=> $stable(mark)); // R10
endmodule

bind secrtc_core secrtc_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_s_n),
  .tick    (tick),
  .frz     (frz),
  .srst    (srst),
  .ld_any  (ld_any),
  .up      (up),
  .dn      (dn),
  .mark    (mark_q),
  .mark_wr (mark_wr),
  .stat    (stat_vec),
  .en      (en_vec),
  .onsw    (onsw)
);

// File: tb/secrtc_core_tb_top.sv
module secrtc_core_tb_top;
  localparam int AW = 8;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, onsw;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  secrtc_core #(.ADDR_W(AW), .SCRATCH_WORDS(NW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .onsw      (onsw)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit unmapped(input int a);
    return (a >= 'h1C && a < 'h80) || (a >= 'h80 + 4 * NW);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [31:0] u, d;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: every aligned offset reads zero after reset
    for (int a = 0; a < 256; a += 4) rd_chk("R1", 8'(a), 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 onsw", {31'b0, onsw}, 32'h0);

    // R3: counter write while running is ignored
    wr(8'h00, 32'd5);
    rd_chk("R3 ignored load", 8'h00, 32'h0);

    // R3: load under freeze, ticks have no effect
    wr(8'h10, 32'h40);
    wr(8'h00, 32'd100);
    wr(8'h04, ~32'd100);
    rd_chk("R3 load up", 8'h00, 32'd100);
    rd_chk("R3 load dn", 8'h04, ~32'd100);
    for (int i = 0; i < 3; i++) pulse_tick();
    rd_chk("R3 frozen up", 8'h00, 32'd100);
    rd_chk("R3 frozen dn", 8'h04, ~32'd100);

    // R2: count and complement invariant
    wr(8'h10, 32'h0);
    for (int n = 1; n <= 40; n++) begin
      pulse_tick();
      rd(8'h00, u);
      rd(8'h04, d);
      check("R2 up", u, 32'd100 + 32'(n));
      check("R2 sum", u + d, 32'hFFFF_FFFF);
    end

    // R5, R4, R7: match at all ones and wrap
    wr(8'h10, 32'h40);
    wr(8'h00, 32'hFFFF_FFFD);
    wr(8'h04, 32'h0000_0002);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h10, 32'h01);
    pulse_tick();
    rd_chk("R4 no early flag", 8'h14, 32'h0);
    pulse_tick();
    rd_chk("R5 up at top", 8'h00, 32'hFFFF_FFFF);
    rd_chk("R5 match at top", 8'h14, 32'h1);
    check("R7 irq on", {31'b0, irq}, 32'h1);
    pulse_tick();
    rd_chk("R5 wrap up", 8'h00, 32'h0);
    rd_chk("R5 wrap dn", 8'h04, 32'hFFFF_FFFF);
    rd_chk("R4 flag latched", 8'h14, 32'h1);

    // R6: write-one-to-clear, condition gone
    wr(8'h14, 32'h1);
    rd_chk("R6 cleared", 8'h14, 32'h0);
    check("R7 irq off", {31'b0, irq}, 32'h0);

    // R4: match via compare write; R6: zero write and clear while true
    wr(8'h08, 32'h0);
    rd_chk("R4 compare write", 8'h14, 32'h1);
    wr(8'h14, 32'h0);
    rd_chk("R6 zero write", 8'h14, 32'h1);
    wr(8'h14, 32'h1);
    rd_chk("R6 re-set", 8'h14, 32'h1);
    wr(8'h10, 32'h0);
    check("R7 masked", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h1);
    idle(2);
    rd_chk("R4 no set when disabled", 8'h14, 32'h0);

    // R4, R8: match1 by counter load, power-switch output
    wr(8'h10, 32'h4A);
    wr(8'h0C, 32'h55);
    wr(8'h00, 32'h55);
    idle(2);
    rd_chk("R8 stat both", 8'h14, 32'h6);
    check("R8 onsw sel1", {31'b0, onsw}, 32'h1);
    check("R7 irq match1", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h4);
    idle(2);
    rd_chk("R8 sw flag clear", 8'h14, 32'h2);
    wr(8'h10, 32'h42);
    check("R8 onsw off", {31'b0, onsw}, 32'h0);
    wr(8'h10, 32'hC2);
    check("R8 onsw forced", {31'b0, onsw}, 32'h1);
    idle(1);
    rd_chk("R8 sw flag on force", 8'h14, 32'h6);

    // R9, R10, R11: software reset keeps marker, compares, scratch
    wr(8'h18, 32'hB5C1_3F27);
    wr(8'h80, 32'h1234_5678);
    wr(8'h10, 32'hD2);
    rd_chk("R9 ctrl", 8'h10, 32'h10);
    rd_chk("R9 up", 8'h00, 32'h0);
    rd_chk("R9 dn", 8'h04, 32'h0);
    rd_chk("R9 stat", 8'h14, 32'h0);
    check("R9 onsw", {31'b0, onsw}, 32'h0);
    check("R9 irq", {31'b0, irq}, 32'h0);
    pulse_tick();
    rd_chk("R9 tick held", 8'h00, 32'h0);
    rd_chk("R9 cmp0 kept", 8'h08, 32'h0);
    rd_chk("R9 cmp1 kept", 8'h0C, 32'h55);
    rd_chk("R10 marker kept", 8'h18, 32'hB5C1_3F27);
    rd_chk("R11 scratch kept", 8'h80, 32'h1234_5678);
    wr(8'h10, 32'h0);
    rd_chk("R10 marker after release", 8'h18, 32'hB5C1_3F27);

    // R11: scratch sweep
    for (int i = 0; i < NW; i++) wr(8'(8'h80 + 4 * i), (32'(i) * 32'h0101_0101) ^ 32'hA5A5_A5A5);
    for (int i = 0; i < NW; i++) rd_chk("R11", 8'(8'h80 + 4 * i), (32'(i) * 32'h0101_0101) ^ 32'hA5A5_A5A5);

    // R12: unmapped and misaligned accesses
    for (int a = 0; a < 256; a += 4) if (unmapped(a)) wr(8'(a), 32'hFFFF_FFFF);
    wr(8'h19, 32'h0);
    wr(8'h81, 32'h0);
    for (int a = 0; a < 256; a += 4) if (unmapped(a)) rd_chk("R12 unmapped", 8'(a), 32'h0);
    rd_chk("R12 misaligned read", 8'h1A, 32'h0);
    rd_chk("R12 marker intact", 8'h18, 32'hB5C1_3F27);
    rd_chk("R12 scratch intact", 8'h80, 32'hA5A5_A5A5);
    wr(8'h10, 32'hFFFF_FF20);
    rd_chk("R12 ctrl reserved", 8'h10, 32'h0);

    summary();
    $finish;
  end
endmodule